// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works beside a simple 32-bit processor core. Each cycle it looks at the exception request lines, the decoded instruction flags, the current program counter and the current status word. It then selects at most one control-flow change. On an exception entry it sends the core a jump to a fixed word-aligned slot. It also produces the new status word, with the mode changed and interrupts masked. For the target mode's bank it produces one write of the old status into the saved-status register and one write of the return address into the link register.

The block also handles return-with-restore. In that case the jump target is taken from the link value the core supplies, and the status word is replaced by the saved-status value in the same step. The core marks a trap instruction with a strobe. The sequencer checks the trap pattern in the instruction word itself, and sends any strobe whose pattern does not match to the undefined-instruction slot.

The block is a single registered stage. The decision is computed combinationally from the inputs and shows on the outputs one clock later, for exactly one cycle per cycle of request.

Top module: `exc_entry_unit`

## Requirements
- R1: Jump targets are fixed slots. Reset goes to 0x00, undefined instruction to 0x04, software trap to 0x08, prefetch abort to 0x0C, data abort to 0x10, normal interrupt to 0x18 and fast interrupt to 0x1C.
- R2: When several requests are present, exactly one is served, in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software trap, return. A reset entry writes neither bank register and sets status bits 7 and 6.
- R3: A trap strobe is taken as a software trap only when bits 27:24 of the instruction word are 4'b1111. Bits 31:28 and 23:0 have no effect. A strobe with any other value in bits 27:24, or an illegal-opcode strobe, causes an undefined-instruction entry.
- R4: On entry, status bits 4:0 take the target mode: supervisor 5'b10011 for reset and trap, undefined 5'b11011, abort 5'b10111 for both aborts, interrupt 5'b10010, fast interrupt 5'b10001. Bit 7 is set. Bit 6 is set for fast interrupt and reset and is kept otherwise. All other bits are kept.
- R5: Every entry except reset writes the current status word to the saved-status register. `bank_sel` carries the target mode code.
- R6: Every entry except reset writes the link register of the same bank with (current PC + 4) with bits 1:0 cleared. Every jump target has bits 1:0 at zero.
- R7: A normal interrupt request is ignored while status bit 7 is set. A fast interrupt request is ignored while status bit 6 is set. A masked request leaves lower-priority requests free to be served.
- R8: A return request with no exception pending jumps to `link_in` with bits 1:0 cleared, loads `status_next` from `saved_status_in`, and writes no bank register.
- R9: Results appear on the clock edge after the inputs and last one cycle. When `redirect_vld` is low, every other output is zero. The synchronous active-low `rst_n` forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_reset_req | input | 1 | Reset exception request |
| dabt_req | input | 1 | Data abort request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| pabt_req | input | 1 | Prefetch abort request |
| illegal_stb | input | 1 | Core found an illegal opcode |
| trap_stb | input | 1 | Core decoded a trap instruction |
| instr_word | input | 32 | Instruction word under decode |
| ret_req | input | 1 | Return with status restore |
| link_in | input | 32 | Link value for return |
| saved_status_in | input | 32 | Saved status value for return |
| cur_pc | input | 32 | PC of the current instruction |
| cur_status | input | 32 | Current status word |
| redirect_vld | output | 1 | A jump and status update are issued |
| redirect_pc | output | 32 | Jump target |
| status_next | output | 32 | New status word |
| bank_sel | output | 5 | Mode code of the bank written |
| saved_we | output | 1 | Saved-status write enable |
| saved_wdata | output | 32 | Saved-status write data |
| link_we | output | 1 | Link register write enable |
| link_wdata | output | 32 | Link register write data |

## Verification
Every output of this block comes from one register stage, so each result is due at the first rising edge after the inputs that caused it. The bench changes inputs on a falling edge and compares outputs on the next falling edge, which is half a period after the registering edge. For held-request tests it compares on each following falling edge, and after the request is dropped it checks one falling edge later that the pulse has ended. The in-reset check samples while `rst_n` is still low, so it sees the forced zero state and never a value loaded from the stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;
    // Mode codes held in status bits 4:0
    localparam int          MODE_W   = 5;
    localparam logic [4:0]  MODE_USR = 5'b10000;
    localparam logic [4:0]  MODE_FIQ = 5'b10001;
    localparam logic [4:0]  MODE_IRQ = 5'b10010;
    localparam logic [4:0]  MODE_SVC = 5'b10011;
    localparam logic [4:0]  MODE_ABT = 5'b10111;
    localparam logic [4:0]  MODE_UND = 5'b11011;

    // Status bit positions
    localparam int BIT_IDIS = 7;
    localparam int BIT_FDIS = 6;

    // Trap pattern location in the instruction word
    localparam int         TRAP_LSB = 24;
    localparam int         TRAP_W   = 4;
    localparam logic [3:0] TRAP_PAT = 4'b1111;

    // Event kinds; the order below 'none' is the service priority
    localparam int EV_N = 8;
    typedef enum logic [3:0] {
        EV_NONE  = 4'd0,
        EV_RESET = 4'd1,
        EV_DABT  = 4'd2,
        EV_FIQ   = 4'd3,
        EV_IRQ   = 4'd4,
        EV_PABT  = 4'd5,
        EV_UNDEF = 4'd6,
        EV_SWI   = 4'd7,
        EV_RET   = 4'd8
    } ev_kind_t;

    // Slot index (word number) of each exception kind
    function automatic logic [2:0] slot_of(ev_kind_t k);
        case (k)
            EV_UNDEF: slot_of = 3'd1;
            EV_SWI:   slot_of = 3'd2;
            EV_PABT:  slot_of = 3'd3;
            EV_DABT:  slot_of = 3'd4;
            EV_IRQ:   slot_of = 3'd6;
            EV_FIQ:   slot_of = 3'd7;
            default:  slot_of = 3'd0;
        endcase
    endfunction

    // Target mode of each exception kind
    function automatic logic [4:0] mode_of(ev_kind_t k);
        case (k)
            EV_UNDEF:        mode_of = MODE_UND;
            EV_PABT, EV_DABT: mode_of = MODE_ABT;
            EV_IRQ:          mode_of = MODE_IRQ;
            EV_FIQ:          mode_of = MODE_FIQ;
            default:         mode_of = MODE_SVC;
        endcase
    endfunction
endpackage

// File: rtl/exc_trap_decode.sv
// Trap/undefined classifier.
// Turns the core's trap and illegal-opcode strobes into a software-trap hit
// or an undefined-instruction hit. Assumes instr_word is the word that was
// decoded in the same cycle as the strobes.
module exc_trap_decode
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr_word,
    input  logic            trap_stb,
    input  logic            illegal_stb,
    output logic            swi_hit,
    output logic            undef_hit
);
    logic pat_ok;

    // Compare the trap field against the fixed pattern
    always_comb begin
        pat_ok    = (instr_word[TRAP_LSB +: TRAP_W] == TRAP_PAT);
        swi_hit   = trap_stb & pat_ok;
        undef_hit = illegal_stb | (trap_stb & ~pat_ok);
    end
endmodule

// File: rtl/exc_prio_arb.sv
// Fixed-priority event selector.
// Masks the interrupt requests with the current disable bits, then picks the
// highest-priority live request; return is served only when nothing else is.
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic     rst_req,
    input  logic     dabt_req,
    input  logic     fiq_req,
    input  logic     irq_req,
    input  logic     pabt_req,
    input  logic     undef_hit,
    input  logic     swi_hit,
    input  logic     ret_req,
    input  logic     idis,
    input  logic     fdis,
    output ev_kind_t kind
);
    logic [EV_N-1:0] live;

    // Build the request vector in priority order (bit 0 highest)
    always_comb begin
        live = {ret_req, swi_hit, undef_hit, pabt_req,
                irq_req & ~idis, fiq_req & ~fdis, dabt_req, rst_req};
    end

    // Pick the first set bit
    always_comb begin
        kind = EV_NONE;
        for (int i = EV_N - 1; i >= 0; i--) begin
            if (live[i]) kind = ev_kind_t'(i + 1);
        end
    end
endmodule

// File: rtl/exc_frame_gen.sv
// Entry/return frame builder.
// For the selected event kind, builds the jump target, the new status word
// and the bank writes. Everything is zero when no event is selected.
module exc_frame_gen
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ev_kind_t         kind,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_status,
    input  logic [XLEN-1:0]  link_in,
    input  logic [XLEN-1:0]  saved_status_in,
    output logic             f_vld,
    output logic [XLEN-1:0]  f_pc,
    output logic [XLEN-1:0]  f_status,
    output logic [MODE_W-1:0] f_bank,
    output logic             f_swe,
    output logic [XLEN-1:0]  f_swd,
    output logic             f_lwe,
    output logic [XLEN-1:0]  f_lwd
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic [XLEN-1:0] next_link;
    logic [4:0]      tmode;

    // Return address of the interrupted instruction, word aligned
    always_comb begin
        next_link = (cur_pc + XLEN'(4)) & ALIGN_MASK;
        tmode     = mode_of(kind);
    end

    // Frame contents per event kind
    always_comb begin
        f_vld    = 1'b0;
        f_pc     = '0;
        f_status = '0;
        f_bank   = '0;
        f_swe    = 1'b0;
        f_swd    = '0;
        f_lwe    = 1'b0;
        f_lwd    = '0;
        case (kind)
            EV_NONE: ;
            EV_RET: begin
                f_vld    = 1'b1;
                f_pc     = link_in & ALIGN_MASK;
                f_status = saved_status_in;
            end
            default: begin
                f_vld              = 1'b1;
                f_pc               = XLEN'({slot_of(kind), 2'b00});
                f_status           = cur_status;
                f_status[4:0]      = tmode;
                f_status[BIT_IDIS] = 1'b1;
                if (kind == EV_FIQ || kind == EV_RESET)
                    f_status[BIT_FDIS] = 1'b1;
                if (kind != EV_RESET) begin
                    f_bank = tmode;
                    f_swe  = 1'b1;
                    f_swd  = cur_status;
                    f_lwe  = 1'b1;
                    f_lwd  = next_link;
                end
            end
        endcase
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry and return sequencer (top).
// Classifies trap strobes, arbitrates requests and registers one frame per
// cycle. Assumes the core applies redirect/status/bank writes in the cycle
// redirect_vld is high and holds inputs stable across the sampling edge.
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_reset_req,
    input  logic              dabt_req,
    input  logic              fiq_req,
    input  logic              irq_req,
    input  logic              pabt_req,
    input  logic              illegal_stb,
    input  logic              trap_stb,
    input  logic [XLEN-1:0]   instr_word,
    input  logic              ret_req,
    input  logic [XLEN-1:0]   link_in,
    input  logic [XLEN-1:0]   saved_status_in,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_status,
    output logic              redirect_vld,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [XLEN-1:0]   status_next,
    output logic [MODE_W-1:0] bank_sel,
    output logic              saved_we,
    output logic [XLEN-1:0]   saved_wdata,
    output logic              link_we,
    output logic [XLEN-1:0]   link_wdata
);
    logic              swi_hit, undef_hit;
    ev_kind_t          kind;
    logic              f_vld, f_swe, f_lwe;
    logic [XLEN-1:0]   f_pc, f_status, f_swd, f_lwd;
    logic [MODE_W-1:0] f_bank;

    exc_trap_decode #(.XLEN(XLEN)) i_dec (
        .instr_word  (instr_word),
        .trap_stb    (trap_stb),
        .illegal_stb (illegal_stb),
        .swi_hit     (swi_hit),
        .undef_hit   (undef_hit)
    );

    exc_prio_arb i_arb (
        .rst_req   (exc_reset_req),
        .dabt_req  (dabt_req),
        .fiq_req   (fiq_req),
        .irq_req   (irq_req),
        .pabt_req  (pabt_req),
        .undef_hit (undef_hit),
        .swi_hit   (swi_hit),
        .ret_req   (ret_req),
        .idis      (cur_status[BIT_IDIS]),
        .fdis      (cur_status[BIT_FDIS]),
        .kind      (kind)
    );

    exc_frame_gen #(.XLEN(XLEN)) i_frm (
        .kind            (kind),
        .cur_pc          (cur_pc),
        .cur_status      (cur_status),
        .link_in         (link_in),
        .saved_status_in (saved_status_in),
        .f_vld           (f_vld),
        .f_pc            (f_pc),
        .f_status        (f_status),
        .f_bank          (f_bank),
        .f_swe           (f_swe),
        .f_swd           (f_swd),
        .f_lwe           (f_lwe),
        .f_lwd           (f_lwd)
    );

    // One-cycle output register for the selected frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
            status_next  <= '0;
            bank_sel     <= '0;
            saved_we     <= 1'b0;
            saved_wdata  <= '0;
            link_we      <= 1'b0;
            link_wdata   <= '0;
        end else begin
            redirect_vld <= f_vld;
            redirect_pc  <= f_pc;
            status_next  <= f_status;
            bank_sel     <= f_bank;
            saved_we     <= f_swe;
            saved_wdata  <= f_swd;
            link_we      <= f_lwe;
            link_wdata   <= f_lwd;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the sequencer, bound to every exc_entry_unit.
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_reset_req,
    input logic              dabt_req,
    input logic              fiq_req,
    input logic              irq_req,
    input logic              pabt_req,
    input logic              illegal_stb,
    input logic              trap_stb,
    input logic [XLEN-1:0]   instr_word,
    input logic              ret_req,
    input logic [XLEN-1:0]   link_in,
    input logic [XLEN-1:0]   saved_status_in,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_status,
    input logic              redirect_vld,
    input logic [XLEN-1:0]   redirect_pc,
    input logic [XLEN-1:0]   status_next,
    input logic [MODE_W-1:0] bank_sel,
    input logic              saved_we,
    input logic [XLEN-1:0]   saved_wdata,
    input logic              link_we,
    input logic [XLEN-1:0]   link_wdata
);
    // R6: jump targets are word aligned
    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> redirect_pc[1:0] == 2'b00);

    // R2: reset request wins and saves nothing
    p_reset_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_reset_req)) |->
        (redirect_vld && redirect_pc == '0 && !saved_we && !link_we
         && status_next[7:6] == 2'b11));

    // R5: trap slot comes with supervisor mode and both bank writes
    p_swi_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && redirect_pc == XLEN'(8)) |->
        (status_next[4:0] == MODE_SVC && status_next[7] && saved_we
         && link_we && bank_sel == MODE_SVC));

    // R7: a normal-interrupt entry only when it was unmasked
    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && bank_sel == MODE_IRQ) |-> !$past(cur_status[7]));

    // R7: a fast-interrupt entry only when it was unmasked
    p_fiq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && bank_sel == MODE_FIQ) |-> !$past(cur_status[6]));

    // R8: a lone return restores status and jumps to the link
    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ret_req) && !$past(exc_reset_req)
         && !$past(dabt_req) && !$past(fiq_req) && !$past(irq_req)
         && !$past(pabt_req) && !$past(illegal_stb) && !$past(trap_stb)) |->
        (redirect_vld && redirect_pc == ($past(link_in) & ~XLEN'(3))
         && status_next == $past(saved_status_in) && !saved_we && !link_we));

    // R9: idle outputs are zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_vld |-> (!saved_we && !link_we && redirect_pc == '0
                           && status_next == '0));
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_exc_entry_unit.sv
`timescale 1ns/1ps
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_reset_req = 0, dabt_req = 0, fiq_req = 0, irq_req = 0;
    logic        pabt_req = 0, illegal_stb = 0, trap_stb = 0, ret_req = 0;
    logic [31:0] instr_word = '0, cur_pc = '0, cur_status = '0;
    logic [31:0] link_in = 32'h0000_4003, saved_status_in = 32'h6000_0010;
    logic        redirect_vld, saved_we, link_we;
    logic [31:0] redirect_pc, status_next, saved_wdata, link_wdata;
    logic [4:0]  bank_sel;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (.*);

    // req bits: {reset, dabt, fiq, irq, pabt, illegal, trap, ret}
    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] instr;
        logic [31:0] pc;
        logic [31:0] st;
        logic        vld;
        logic [31:0] epc;
        logic [31:0] est;
        logic        wr;
        logic [4:0]  bank;
        logic [31:0] elr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        // R1 R3 R4 R5 R6: trap with matching pattern
        '{8'b0000_0010, 32'hEF00_0010, 32'h0000_1000, 32'h0000_0010, 1'b1, 32'h08, 32'h0000_0093, 1'b1, 5'h13, 32'h0000_1004},
        // R3: trap strobe with wrong pattern -> undefined
        '{8'b0000_0010, 32'hEE00_0000, 32'h0000_1100, 32'h0000_0010, 1'b1, 32'h04, 32'h0000_009B, 1'b1, 5'h1B, 32'h0000_1104},
        // R3: illegal opcode strobe -> undefined
        '{8'b0000_0100, 32'h0000_0000, 32'h0000_2000, 32'h0000_0010, 1'b1, 32'h04, 32'h0000_009B, 1'b1, 5'h1B, 32'h0000_2004},
        // R1 R4: normal interrupt
        '{8'b0001_0000, 32'h0000_0000, 32'h0000_3000, 32'h0000_0010, 1'b1, 32'h18, 32'h0000_0092, 1'b1, 5'h12, 32'h0000_3004},
        // R7: normal interrupt masked
        '{8'b0001_0000, 32'h0000_0000, 32'h0000_3000, 32'h0000_0090, 1'b0, 32'h00, 32'h0000_0000, 1'b0, 5'h00, 32'h0000_0000},
        // R1 R4: fast interrupt sets both disables
        '{8'b0010_0000, 32'h0000_0000, 32'h0000_3008, 32'h0000_0010, 1'b1, 32'h1C, 32'h0000_00D1, 1'b1, 5'h11, 32'h0000_300C},
        // R7: fast masked, normal served
        '{8'b0011_0000, 32'h0000_0000, 32'h0000_3010, 32'h0000_0050, 1'b1, 32'h18, 32'h0000_00D2, 1'b1, 5'h12, 32'h0000_3014},
        // R2: data abort beats fast and normal
        '{8'b0111_0000, 32'h0000_0000, 32'h0000_5000, 32'h0000_0010, 1'b1, 32'h10, 32'h0000_0097, 1'b1, 5'h17, 32'h0000_5004},
        // R2: prefetch abort beats undefined
        '{8'b0000_1100, 32'h0000_0000, 32'h0000_5100, 32'h0000_0010, 1'b1, 32'h0C, 32'h0000_0097, 1'b1, 5'h17, 32'h0000_5104},
        // R2: undefined beats trap
        '{8'b0000_0110, 32'hEF00_0000, 32'h0000_5200, 32'h0000_0010, 1'b1, 32'h04, 32'h0000_009B, 1'b1, 5'h1B, 32'h0000_5204},
        // R2: reset beats all, no bank writes
        '{8'b1100_0001, 32'h0000_0000, 32'h0000_5300, 32'h0000_0010, 1'b1, 32'h00, 32'h0000_00D3, 1'b0, 5'h00, 32'h0000_0000},
        // R8: lone return
        '{8'b0000_0001, 32'h0000_0000, 32'h0000_5400, 32'h0000_0093, 1'b1, 32'h4000, 32'h6000_0010, 1'b0, 5'h00, 32'h0000_0000},
        // R8 R2: interrupt beats return
        '{8'b0001_0001, 32'h0000_0000, 32'h0000_5500, 32'h0000_0010, 1'b1, 32'h18, 32'h0000_0092, 1'b1, 5'h12, 32'h0000_5504},
        // R6: unaligned PC gives aligned link
        '{8'b0000_0010, 32'h1F12_3456, 32'h0000_1002, 32'h0000_0010, 1'b1, 32'h08, 32'h0000_0093, 1'b1, 5'h13, 32'h0000_1004},
        // R4: upper status bits kept
        '{8'b0000_1000, 32'h0000_0000, 32'h0000_6000, 32'hF000_0010, 1'b1, 32'h0C, 32'hF000_0097, 1'b1, 5'h17, 32'h0000_6004}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        {exc_reset_req, dabt_req, fiq_req, irq_req, pabt_req, illegal_stb, trap_stb, ret_req} = '0;
        instr_word = '0; cur_pc = '0; cur_status = '0;
    endtask

    task automatic all_zero(input string tag);
        chk({tag, " vld"},  32'(redirect_vld), 32'd0);
        chk({tag, " pc"},   redirect_pc, 32'd0);
        chk({tag, " st"},   status_next, 32'd0);
        chk({tag, " we"},   32'({saved_we, link_we}), 32'd0);
        chk({tag, " data"}, saved_wdata | link_wdata | 32'(bank_sel), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: held in reset with a request present -> zero outputs
        trap_stb = 1; instr_word = 32'hEF00_0000;
        repeat (3) @(negedge clk);
        all_zero("R9 reset");
        clear_in();
        rst_n = 1;
        @(negedge clk);
        all_zero("R9 idle");

        // Table walk: inputs at one falling edge, results at the next
        for (int i = 0; i < NV; i++) begin
            {exc_reset_req, dabt_req, fiq_req, irq_req, pabt_req, illegal_stb, trap_stb, ret_req} = VT[i].req;
            instr_word = VT[i].instr;
            cur_pc     = VT[i].pc;
            cur_status = VT[i].st;
            @(negedge clk);
            chk($sformatf("R1/R2 vec%0d vld", i), 32'(redirect_vld), 32'(VT[i].vld));
            chk($sformatf("R1/R8 vec%0d pc", i), redirect_pc, VT[i].epc);
            chk($sformatf("R4/R8 vec%0d status", i), status_next, VT[i].est);
            chk($sformatf("R5 vec%0d saved_we", i), 32'(saved_we), 32'(VT[i].wr));
            chk($sformatf("R5 vec%0d saved_wdata", i), saved_wdata, VT[i].wr ? VT[i].st : 32'd0);
            chk($sformatf("R5 vec%0d bank", i), 32'(bank_sel), 32'(VT[i].bank));
            chk($sformatf("R6 vec%0d link_we", i), 32'(link_we), 32'(VT[i].wr));
            chk($sformatf("R6 vec%0d link_wdata", i), link_wdata, VT[i].elr);
        end

        // R9: request dropped -> pulse ends one edge later
        clear_in();
        @(negedge clk);
        all_zero("R9 drop");

        // R9: held request repeats each cycle, then stops
        irq_req = 1; cur_pc = 32'h0000_7000; cur_status = 32'h10;
        @(negedge clk);
        chk("R9 held c1 pc", redirect_pc, 32'h18);
        @(negedge clk);
        chk("R9 held c2 link", link_wdata, 32'h0000_7004);
        clear_in();
        @(negedge clk);
        all_zero("R9 held end");

        // R8: return with different link and saved status
        ret_req = 1; link_in = 32'h8000_0122; saved_status_in = 32'h2000_00D3;
        @(negedge clk);
        chk("R8 ret pc", redirect_pc, 32'h8000_0120);
        chk("R8 ret st", status_next, 32'h2000_00D3);
        chk("R8 ret no write", 32'({saved_we, link_we}), 32'd0);
        clear_in();

        // R9: synchronous reset mid-stream clears outputs
        trap_stb = 1; instr_word = 32'hEF00_0000; cur_pc = 32'h100;
        @(negedge clk);
        chk("R9 pre-reset vld", 32'(redirect_vld), 32'd1);
        rst_n = 0;
        @(negedge clk);
        all_zero("R9 mid reset");
        clear_in();
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule